// File: doc/BRIEF.md
# Ping-Pong Block Deinterleaver Buffer

This block sits between a deinterleaver address generator and the decoder. It reorders one OFDM symbol's worth of coded bits at a time. It holds two single-bit memory banks. While one bank is being filled, the other is drained.

- **Filling:** each incoming bit is stored at the position given by an external permutation address.
- **Draining:** bits are read back in plain ascending address order.

The two banks swap roles as soon as a full block of the programmed length has been written. As a result, a continuous input stream produces a continuous, permuted output stream one block later, with no stall at the block boundary.

Writing and reading advance together, one bit per valid input beat. A pause on the input pauses the fill, the drain and the swap alike. The block length is chosen from three sizes by a small select field. That field is only looked at on the first beat of each block, so a new size starts cleanly at a block boundary.

Top module: `ddi_pingpong_buf`

## Requirements
- R1: From reset, and until the first complete block has been written, `out_valid` stays low. The first block fills the bank that is not drained first, so no stale data is ever presented.
- R2: A beat with `in_valid` high stores `in_bit` at `in_addr` of the fill bank. After the swap, the drained block comes out in ascending address order, 0 first. So the k-th output bit of a block is the bit that was written with address k.
- R3: `size_sel` encodes the block length: 0 gives 96, 1 gives 192, 2 or 3 gives 288. It is sampled only on the first valid beat of a block. Changing it on any later beat of the same block has no effect.
- R4: On the valid beat that writes the last position of a block (beat number length−1, counting from 0), the banks swap. The next valid beat writes the new block at count 0 and drains the just-completed block starting at address 0.
- R5: Once primed, every valid input beat produces exactly one output bit. `out_valid` rises one clock after that beat, and `out_bit` is valid in the same cycle.
- R6: While `in_valid` is low, no count, swap or bank state advances. `out_valid` is low in the following cycle.
- R7: A valid beat whose `in_addr` is at or above the current block length writes nothing. The addressed bank keeps its earlier content, but the beat still counts toward the block length.
- R8: With `in_valid` held high across block boundaries, the output stream has no gap. `out_valid` stays high through every swap.
- R9: After a size change, the previously completed block is drained over the new block length. Positions beyond the old length return whatever that bank last held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat qualifier |
| in_bit | input | 1 | Coded bit to store |
| in_addr | input | 9 | Permuted write address for `in_bit` |
| size_sel | input | 2 | Block length select (0:96, 1:192, 2/3:288) |
| out_valid | output | 1 | Output beat qualifier |
| out_bit | output | 1 | Deinterleaved bit, ascending address order |

## Verification
On the final beat of every block, three things happen on the same clock edge: the last write into the fill bank, the last read from the drain bank, and the bank swap. Right after that edge, the opposite bank must be the one read from address 0.

The stimulus provokes this boundary under three conditions:
- back-to-back blocks with no idle cycles;
- blocks with random idle gaps, including gaps that land right before and right after the final beat;
- blocks whose length differs from the one before.

A per-cycle bench model of both banks judges each output. It predicts `out_valid` and `out_bit` one clock after every beat, so a swap that is one beat early or late, or a read taken from the wrong bank, shows up as a mismatch.

// File: rtl/ddi_pkg.sv
package ddi_pkg;
  // Which of the two storage banks is meant
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  // Width of the block-length select field
  localparam int SIZE_SEL_W = 2;
endpackage

// File: rtl/ddi_wr_ctrl.sv
// Fill side: block length capture, write count, swap decision, bank select
module ddi_wr_ctrl
  import ddi_pkg::*;
#(
  parameter int LEN_S0 = 96,
  parameter int LEN_S1 = 192,
  parameter int LEN_S2 = 288,
  parameter int AW     = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [SIZE_SEL_W-1:0] size_sel,
  input  logic [AW-1:0]         in_addr,
  output bank_e                 wr_bank,
  output logic                  wr_en,
  output logic                  swap,
  output logic [AW-1:0]         wr_cnt,
  output logic [AW-1:0]         cur_len
);
  localparam logic [AW-1:0] L0 = AW'(LEN_S0);
  localparam logic [AW-1:0] L1 = AW'(LEN_S1);
  localparam logic [AW-1:0] L2 = AW'(LEN_S2);

  logic [AW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] len_q, len_d;
  bank_e         bank_q, bank_d;
  logic [AW-1:0] sel_len;
  logic [AW-1:0] eff_len;
  logic          first_beat;
  logic          last_beat;

  // Decode of the length select field
  always_comb begin
    case (size_sel)
      2'd0:    sel_len = L0;
      2'd1:    sel_len = L1;
      default: sel_len = L2;
    endcase
  end

  // The length is taken from the select field only at count 0
  assign first_beat = (cnt_q == '0);
  assign eff_len    = first_beat ? sel_len : len_q;
  assign last_beat  = in_valid && (cnt_q == eff_len - AW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    bank_d = bank_q;
    if (in_valid) begin
      if (first_beat) len_d = sel_len;
      if (last_beat) begin
        cnt_d  = '0;
        bank_d = (bank_q == BANK_A) ? BANK_B : BANK_A;
      end else begin
        cnt_d = cnt_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= L0;
      bank_q <= BANK_B;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      bank_q <= bank_d;
    end
  end

  assign wr_bank = bank_q;
  assign wr_en   = in_valid && (in_addr < eff_len);
  assign swap    = last_beat;
  assign wr_cnt  = cnt_q;
  assign cur_len = eff_len;
endmodule

// File: rtl/ddi_rd_ctrl.sv
// Drain side: linear read count, priming flag, output qualifier
module ddi_rd_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          swap,
  output logic [AW-1:0] rd_addr,
  output logic          rd_en,
  output logic          out_valid
);
  logic [AW-1:0] cnt_q, cnt_d;
  logic          primed_q, primed_d;
  logic          ov_q, ov_d;

  assign rd_en = in_valid && primed_q;

  always_comb begin
    cnt_d    = cnt_q;
    primed_d = primed_q | swap;
    ov_d     = rd_en;
    if (swap)          cnt_d = '0;
    else if (in_valid) cnt_d = cnt_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      ov_q     <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      ov_q     <= ov_d;
    end
  end

  assign rd_addr   = cnt_q;
  assign out_valid = ov_q;
endmodule

// File: rtl/ddi_bank_pair.sv
// Two single-bit banks; one written, the other read into a registered output
module ddi_bank_pair
  import ddi_pkg::*;
#(
  parameter int DEPTH = 288,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  bank_e         wr_bank,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [1:0] bank_rd;
  logic       rd_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DEPTH-1:0] mem_q;
    logic             sel_wr;

    assign sel_wr = wr_en && (wr_bank == bank_e'(b));

    always_ff @(posedge clk) begin
      if (sel_wr) mem_q[wr_addr] <= wr_bit;
    end

    assign bank_rd[b] = mem_q[rd_addr];
  end

  // The drain bank is always the one not being filled
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= (wr_bank == BANK_A) ? bank_rd[1] : bank_rd[0];
  end

  assign rd_bit = rd_q;
endmodule

// File: rtl/ddi_pingpong_buf.sv
module ddi_pingpong_buf
  import ddi_pkg::*;
#(
  parameter int LEN_S0 = 96,
  parameter int LEN_S1 = 192,
  parameter int LEN_S2 = 288,
  parameter int AW     = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_bit,
  input  logic [AW-1:0]         in_addr,
  input  logic [SIZE_SEL_W-1:0] size_sel,
  output logic                  out_valid,
  output logic                  out_bit
);
  localparam int MAX01   = (LEN_S0 > LEN_S1) ? LEN_S0 : LEN_S1;
  localparam int MAX_LEN = (MAX01 > LEN_S2) ? MAX01 : LEN_S2;

  logic          rst_s1_q, rst_sync_n;
  bank_e         wr_bank;
  logic          wr_en;
  logic          swap;
  logic [AW-1:0] wr_cnt;
  logic [AW-1:0] cur_len;
  logic [AW-1:0] rd_addr;
  logic          rd_en;

  // Reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  ddi_wr_ctrl #(
    .LEN_S0(LEN_S0), .LEN_S1(LEN_S1), .LEN_S2(LEN_S2), .AW(AW)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .size_sel (size_sel),
    .in_addr  (in_addr),
    .wr_bank  (wr_bank),
    .wr_en    (wr_en),
    .swap     (swap),
    .wr_cnt   (wr_cnt),
    .cur_len  (cur_len)
  );

  ddi_rd_ctrl #(.AW(AW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .swap      (swap),
    .rd_addr   (rd_addr),
    .rd_en     (rd_en),
    .out_valid (out_valid)
  );

  ddi_bank_pair #(.DEPTH(MAX_LEN), .AW(AW)) u_mem (
    .clk     (clk),
    .wr_bank (wr_bank),
    .wr_en   (wr_en),
    .wr_addr (in_addr),
    .wr_bit  (in_bit),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_bit  (out_bit)
  );
endmodule

// File: rtl/ddi_pingpong_buf_chk.sv
module ddi_pingpong_buf_chk
  import ddi_pkg::*;
#(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input bank_e         wr_bank,
  input logic          swap,
  input logic [AW-1:0] wr_cnt,
  input logic [AW-1:0] cur_len,
  input logic [AW-1:0] rd_addr
);
  // R6: an idle input cycle yields no output in the next cycle
  a_r6_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5: every output beat is caused by an input beat one cycle earlier
  a_r5_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R4: a swap flips the fill bank
  a_r4_swap_flips: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (wr_bank != $past(wr_bank)));

  // R4, R6: without a swap the fill bank holds
  a_r4_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(wr_bank));

  // R8: fill and drain counts advance in lockstep
  a_r8_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == wr_cnt);

  // R3: the write count never reaches the block length
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt < cur_len);

  // R6: an idle cycle leaves the count unchanged
  a_r6_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wr_cnt));
endmodule

bind ddi_pingpong_buf ddi_pingpong_buf_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .wr_bank   (wr_bank),
  .swap      (swap),
  .wr_cnt    (wr_cnt),
  .cur_len   (cur_len),
  .rd_addr   (rd_addr)
);

// File: tb/ddi_pingpong_buf_bench.sv
`timescale 1ns/1ps
module ddi_pingpong_buf_bench;
  localparam int AW = 9;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic          in_bit;
  logic [AW-1:0] in_addr;
  logic [1:0]    size_sel;
  logic          out_valid;
  logic          out_bit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench model state
  logic [287:0] m_mem [2];
  int    m_sel    = 1;
  int    m_w      = 0;
  int    m_len    = 96;
  bit    m_primed = 0;
  int    prev_len = -1;
  string tag      = "R1";

  ddi_pingpong_buf u_ddi_pingpong_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_addr   (in_addr),
    .size_sel  (size_sel),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int len_of(input int s);
    if (s == 0) return 96;
    if (s == 1) return 192;
    return 288;
  endfunction

  task automatic check_bit(input string req, input logic got, input logic exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got %0b exp %0b", req, what, got, exp);
    end
  endtask

  // Drive one cycle (called just after a falling edge), then compare outputs
  task automatic step(input bit v, input bit b, input int a, input int s);
    logic  ev;
    logic  eb;
    int    len;
    string vtag;
    in_valid = v;
    in_bit   = b;
    in_addr  = AW'(a);
    size_sel = 2'(s);
    ev = 1'b0;
    eb = 1'b0;
    vtag = !m_primed ? "R1" : (!v ? "R6" : "R5");
    if (v) begin
      len = (m_w == 0) ? len_of(s) : m_len;
      if (m_w == 0) m_len = len;
      ev = m_primed;
      eb = m_mem[1 - m_sel][m_w];
      if (a < len) m_mem[m_sel][a] = b;
      if (m_w == len - 1) begin
        m_sel    = 1 - m_sel;
        m_w      = 0;
        m_primed = 1;
      end else begin
        m_w++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check_bit(vtag, out_valid, ev, "out_valid");
    if (ev) check_bit((m_w == 1) ? "R4" : tag, out_bit, eb, "out_bit");
  endtask

  // mode 0: random gaps, 1: continuous, 2: noise on size_sel, 3: out-of-range addresses
  task automatic run_block(input int sz, input int mode);
    int len;
    int stride;
    int off;
    int strides [8] = '{5, 7, 11, 13, 17, 19, 23, 25};
    len    = len_of(sz);
    stride = strides[$urandom % 8];
    off    = $urandom % len;
    if (prev_len >= 0 && prev_len != len) tag = "R9";
    else if (mode == 1) tag = "R8";
    else if (mode == 2) tag = "R3";
    else if (mode == 3) tag = "R7";
    else tag = "R2";
    prev_len = len;
    for (int k = 0; k < len; k++) begin
      int a;
      int s;
      if (mode != 1 && ($urandom % 4) == 0)
        step(1'b0, 1'($urandom), int'($urandom % 512), int'($urandom % 4));
      a = (k * stride + off) % len;
      if (mode == 3 && (k % 10) == 3) a = len + int'($urandom % (512 - len));
      s = (k == 0 || mode != 2) ? sz : int'($urandom % 4);
      step(1'b1, 1'($urandom), a, s);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_bit   = 1'b0;
    in_addr  = '0;
    size_sel = '0;
    repeat (3) @(negedge clk);
    check_bit("R1", out_valid, 1'b0, "out_valid in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0);
    // Two full 288 blocks so every position of both banks is defined
    run_block(2, 1);
    run_block(2, 1);
    for (int i = 0; i < 6; i++) run_block(int'($urandom % 4), 0);
    run_block(0, 3);
    run_block(0, 2);
    run_block(1, 2);
    run_block(2, 0);
    run_block(0, 0);
    run_block(3, 1);
    run_block(1, 1);
    run_block(1, 3);
    run_block(2, 1);
    // Drain the last block
    run_block(2, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule